// File: doc/BRIEF.md
# Per-Thread Squash Walker

This block holds a small in-order entry queue for each hardware thread and, after a misprediction, walks one thread's queue to mark the wrong-path entries. An entry is allocated at the young end of its thread's queue along with a 16-bit sequence number that grows in program order. Retirement removes entries from the old end. A squash request names a thread and a boundary sequence number. From then on the block visits that thread's entries from youngest to oldest, at a bounded rate per cycle. Every entry younger than the boundary gets its squashed flag and its commit-eligible flag set, and it leaves later through ordinary retirement.

Each thread has a registered done flag that is low while its walk is running. A one-cycle tail pulse fires when the walk marks the thread's youngest entry, so that logic outside this block can recompute the global youngest entry. The flags of a retired entry come back one cycle after the retire request.

Top module: `squash_walker`

## Requirements
- R1: After reset every thread's done flag is 1, every tail pulse is 0 and every queue is empty, so a retire request returns ret_valid = 0.
- R2: A squash request for a thread whose queue is empty, including the case where every queue is empty, leaves that thread's done flag at 1 and marks nothing.
- R3: A squash request for a non-empty thread drives its done flag to 0 in the cycle after the request, and the walk starts at that thread's youngest entry on the next cycle.
- R4: A walk marks at most SQ_WIDTH entries per cycle (default 2), so an entry that is k positions from the youngest (k counted from 0) is marked in walk cycle floor(k/SQ_WIDTH)+1.
- R5: Only entries whose sequence number is strictly greater than the boundary are marked, and each marked entry gets both its squashed flag and its commit-eligible flag set.
- R6: The walk ends, with done returning to 1, in the walk cycle that reaches an entry whose sequence number is at or below the boundary, counting the entry just after the last one marked in that cycle. That entry and every older entry stay unmarked.
- R7: The walk also ends in the cycle that marks the thread's current oldest entry.
- R8: tail_update for a thread is high for exactly the one cycle after the walk cycle that marked that thread's youngest entry. A walk that marks nothing raises no pulse.
- R9: A squash request for a thread that is still walking restarts the walk from the youngest entry with the new boundary. The old walk marks nothing further.
- R10: An allocation is ignored when the target thread holds DEPTH entries or while its walk is running (done = 0, or a squash request in the same cycle).
- R11: A retire request for a non-empty thread pops its oldest entry. One cycle later it returns ret_valid = 1, ret_seq and the entry's flags, in allocation order. A retire request for an empty thread returns ret_valid = 0.
- R12: A squash for one thread changes neither the flags nor the done flag of any other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate an entry at the young end |
| alloc_tid | input | TID_W | Thread of the allocation |
| alloc_seq | input | SEQ_W | Sequence number of the new entry |
| retire_valid | input | 1 | Pop the oldest entry of a thread |
| retire_tid | input | TID_W | Thread to retire from |
| squash_valid | input | 1 | Start a squash walk |
| squash_tid | input | TID_W | Thread to squash |
| squash_seq | input | SEQ_W | Boundary; entries above it are squashed |
| ret_valid | output | 1 | Retired entry info is valid |
| ret_seq | output | SEQ_W | Sequence number of the retired entry |
| ret_squashed | output | 1 | Squashed flag of the retired entry |
| ret_commit_ok | output | 1 | Commit-eligible flag of the retired entry |
| walk_done | output | NUM_THREADS | Per-thread walk-finished flag |
| tail_update | output | NUM_THREADS | Per-thread one-cycle youngest-marked pulse |

## Verification
The hardest situations to reach are the ones where the walk is still running while other traffic reaches the same thread. One case is an entry that is retired before the walk gets to it. Another is a second squash that arrives one cycle after the first. A third is an allocation that arrives mid-walk. The directed tasks line these up cycle by cycle from the squash edge. A retire is issued in the first walk cycle, so the oldest entry leaves still unmarked, which shows the per-cycle limit from outside. The shortened queue must then end the walk at the new oldest entry. A restart is timed one cycle after the first request, with a boundary that gives a different marked set and a different finish cycle.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef struct packed {
    logic squashed;
    logic commit_ok;
  } sqw_flags_t;

endpackage

// File: rtl/sqw_mark_chain.sv
module sqw_mark_chain #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int SQ_W  = 2
) (
  input  logic [SEQ_W-1:0]          seq_arr [DEPTH],
  input  logic [$clog2(DEPTH)-1:0]  tail_idx,
  input  logic [$clog2(DEPTH):0]    cnt,
  input  logic [$clog2(DEPTH):0]    pos,
  input  logic [SEQ_W-1:0]          bound,
  output logic [DEPTH-1:0]          mark_vec,
  output logic                      finish,
  output logic                      youngest_hit
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CW    = IDX_W + 1;

  logic            go;
  logic            ok;
  logic [CW:0]     p;
  logic [IDX_W-1:0] idx;

  always_comb begin
    mark_vec     = '0;
    youngest_hit = 1'b0;
    go           = 1'b1;
    ok           = 1'b0;
    p            = '0;
    idx          = '0;
    for (int k = 0; k <= SQ_W; k++) begin
      p   = {1'b0, pos} + (CW+1)'(k);
      idx = tail_idx - IDX_W'(1) - p[IDX_W-1:0];
      ok  = ({1'b0, cnt} > p) && (seq_arr[idx] > bound);
      if (k < SQ_W) begin
        if (go && ok) mark_vec[idx] = 1'b1;
        if (k == 0 && go && ok && pos == '0) youngest_hit = 1'b1;
      end
      go = go && ok;
    end
    finish = !go;
  end

endmodule

// File: rtl/sqw_thread_queue.sv
module sqw_thread_queue
  import sqw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int SQ_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_en,
  input  logic [SEQ_W-1:0]         alloc_seq,
  input  logic                     retire_en,
  input  logic                     sq_req,
  input  logic [SEQ_W-1:0]         sq_bound,
  output logic [SEQ_W-1:0]         head_seq,
  output sqw_flags_t               head_flags,
  output logic [$clog2(DEPTH):0]   occupancy,
  output logic                     done,
  output logic                     tail_pulse
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CW    = IDX_W + 1;

  logic [SEQ_W-1:0] seq_q [DEPTH];
  sqw_flags_t       flg_q [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CW-1:0]    cnt_q, pos_q;
  logic [SEQ_W-1:0] bound_q;
  logic             done_q, tpls_q;

  logic             sq_start, step_en, alloc_ok, ret_ok;
  logic [DEPTH-1:0] mark_vec;
  logic             finish, youngest_hit;

  assign sq_start = sq_req && (cnt_q != '0);
  assign step_en  = !done_q && !sq_start;
  assign alloc_ok = alloc_en && done_q && !sq_start && (cnt_q != CW'(DEPTH));
  assign ret_ok   = retire_en && (cnt_q != '0);

  sqw_mark_chain #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_W(SQ_W)) u_chain (
    .seq_arr      (seq_q),
    .tail_idx     (tail_q),
    .cnt          (cnt_q),
    .pos          (pos_q),
    .bound        (bound_q),
    .mark_vec     (mark_vec),
    .finish       (finish),
    .youngest_hit (youngest_hit)
  );

  always_ff @(posedge clk) begin
    if (alloc_ok) seq_q[tail_q] <= alloc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) flg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (step_en && mark_vec[i]) flg_q[i] <= '{squashed: 1'b1, commit_ok: 1'b1};
      if (alloc_ok) flg_q[tail_q] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      pos_q   <= '0;
      bound_q <= '0;
      done_q  <= 1'b1;
      tpls_q  <= 1'b0;
    end else begin
      tpls_q <= step_en && youngest_hit;
      if (alloc_ok) tail_q <= tail_q + IDX_W'(1);
      if (ret_ok)   head_q <= head_q + IDX_W'(1);
      case ({alloc_ok, ret_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (sq_start) begin
        done_q  <= 1'b0;
        bound_q <= sq_bound;
        pos_q   <= '0;
      end else if (step_en) begin
        if (finish) done_q <= 1'b1;
        else        pos_q  <= pos_q + CW'(SQ_W);
      end
    end
  end

  assign head_seq   = seq_q[head_q];
  assign head_flags = flg_q[head_q];
  assign occupancy  = cnt_q;
  assign done       = done_q;
  assign tail_pulse = tpls_q;

  assert_done_clear_R3: assert property (@(posedge clk) disable iff (rst)
    sq_start |=> !done_q);
  assert_empty_squash_R2: assert property (@(posedge clk) disable iff (rst)
    (sq_req && cnt_q == '0 && done_q) |=> done_q);
  assert_mark_width_R4: assert property (@(posedge clk) disable iff (rst)
    step_en |-> ($countones(mark_vec) <= SQ_W));
  assert_done_after_step_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(step_en));
  assert_tail_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    tpls_q |=> !tpls_q);
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    sq_start |=> (pos_q == '0 && bound_q == $past(sq_bound)));
  assert_alloc_block_R10: assert property (@(posedge clk) disable iff (rst)
    !done_q |=> (tail_q == $past(tail_q)));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/squash_walker.sv
module squash_walker
  import sqw_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 8,
  parameter int SEQ_W       = 16,
  parameter int SQ_WIDTH    = 2,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CW         = $clog2(DEPTH) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   alloc_valid,
  input  logic [TID_W-1:0]       alloc_tid,
  input  logic [SEQ_W-1:0]       alloc_seq,
  input  logic                   retire_valid,
  input  logic [TID_W-1:0]       retire_tid,
  input  logic                   squash_valid,
  input  logic [TID_W-1:0]       squash_tid,
  input  logic [SEQ_W-1:0]       squash_seq,
  output logic                   ret_valid,
  output logic [SEQ_W-1:0]       ret_seq,
  output logic                   ret_squashed,
  output logic                   ret_commit_ok,
  output logic [NUM_THREADS-1:0] walk_done,
  output logic [NUM_THREADS-1:0] tail_update
);

  logic [SEQ_W-1:0] head_seq [NUM_THREADS];
  sqw_flags_t       head_flg [NUM_THREADS];
  logic [CW-1:0]    occ      [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    sqw_thread_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_W(SQ_WIDTH)) u_q (
      .clk        (clk),
      .rst        (rst),
      .alloc_en   (alloc_valid && alloc_tid == TID_W'(t)),
      .alloc_seq  (alloc_seq),
      .retire_en  (retire_valid && retire_tid == TID_W'(t)),
      .sq_req     (squash_valid && squash_tid == TID_W'(t)),
      .sq_bound   (squash_seq),
      .head_seq   (head_seq[t]),
      .head_flags (head_flg[t]),
      .occupancy  (occ[t]),
      .done       (walk_done[t]),
      .tail_pulse (tail_update[t])
    );
  end

  logic sel_ok;
  assign sel_ok = retire_valid && (int'(retire_tid) < NUM_THREADS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid     <= 1'b0;
      ret_seq       <= '0;
      ret_squashed  <= 1'b0;
      ret_commit_ok <= 1'b0;
    end else begin
      ret_valid <= sel_ok && (occ[retire_tid] != '0);
      if (sel_ok) begin
        ret_seq       <= head_seq[retire_tid];
        ret_squashed  <= head_flg[retire_tid].squashed;
        ret_commit_ok <= head_flg[retire_tid].commit_ok;
      end
    end
  end

  assert_ret_cause_R11: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(retire_valid));

endmodule

// File: tb/squash_walker_tb.sv
`timescale 1ns/1ps
module squash_walker_tb;
  localparam int NT = 2;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 0, retire_valid = 0, squash_valid = 0;
  logic [0:0] alloc_tid = '0, retire_tid = '0, squash_tid = '0;
  logic [SW-1:0] alloc_seq = '0, squash_seq = '0;
  logic ret_valid, ret_squashed, ret_commit_ok;
  logic [SW-1:0] ret_seq;
  logic [NT-1:0] walk_done, tail_update;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  squash_walker u_dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
    .retire_valid(retire_valid), .retire_tid(retire_tid),
    .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_seq(squash_seq),
    .ret_valid(ret_valid), .ret_seq(ret_seq), .ret_squashed(ret_squashed),
    .ret_commit_ok(ret_commit_ok), .walk_done(walk_done), .tail_update(tail_update)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alloc(int tid, int seq);
    alloc_valid = 1; alloc_tid = 1'(tid); alloc_seq = SW'(seq);
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic squash(int tid, int seq);
    squash_valid = 1; squash_tid = 1'(tid); squash_seq = SW'(seq);
    @(negedge clk);
    squash_valid = 0;
  endtask

  task automatic retire_chk(string tag, int tid, bit ev, int es, bit esq, bit ecc);
    retire_valid = 1; retire_tid = 1'(tid);
    @(negedge clk);
    retire_valid = 0;
    chk({tag, " valid"}, 32'(ret_valid), 32'(ev));
    if (ev) begin
      chk({tag, " seq"}, 32'(ret_seq), 32'(es));
      chk({tag, " squashed"}, 32'(ret_squashed), 32'(esq));
      chk({tag, " commit_ok"}, 32'(ret_commit_ok), 32'(ecc));
    end
  endtask

  task automatic t_reset();
    chk("R1 done after reset", 32'(walk_done), 32'h3);
    chk("R1 tail pulse after reset", 32'(tail_update), 32'h0);
    retire_chk("R1 empty retire", 0, 0, 0, 0, 0);
  endtask

  task automatic t_empty_squash();
    squash(0, 5);
    chk("R2 done kept on empty squash", 32'(walk_done[0]), 1);
    idle(2);
    chk("R2 done still set", 32'(walk_done), 32'h3);
  endtask

  task automatic t_basic();
    for (int s = 10; s <= 15; s++) alloc(0, s);
    squash(0, 11);
    chk("R3 done cleared", 32'(walk_done[0]), 0);
    chk("R8 no pulse before step", 32'(tail_update[0]), 0);
    idle(1);
    chk("R8 tail pulse", 32'(tail_update[0]), 1);
    chk("R4 walk not finished after one step", 32'(walk_done[0]), 0);
    idle(1);
    chk("R6 done at boundary", 32'(walk_done[0]), 1);
    chk("R8 pulse single cycle", 32'(tail_update[0]), 0);
    retire_chk("R6 seq10", 0, 1, 10, 0, 0);
    retire_chk("R6 boundary seq11", 0, 1, 11, 0, 0);
    for (int s = 12; s <= 15; s++) retire_chk("R5 marked", 0, 1, s, 1, 1);
  endtask

  task automatic t_rate_retire();
    for (int s = 20; s <= 23; s++) alloc(1, s);
    squash(1, 0);
    retire_chk("R4 oldest unmarked in first step", 1, 1, 20, 0, 0);
    chk("R4 walk continues", 32'(walk_done[1]), 0);
    idle(1);
    chk("R7 done at oldest", 32'(walk_done[1]), 1);
    for (int s = 21; s <= 23; s++) retire_chk("R7 marked", 1, 1, s, 1, 1);
  endtask

  task automatic t_oldest();
    for (int s = 30; s <= 32; s++) alloc(0, s);
    squash(0, 29);
    idle(1);
    chk("R7 not yet done", 32'(walk_done[0]), 0);
    idle(1);
    chk("R7 done after oldest", 32'(walk_done[0]), 1);
    for (int s = 30; s <= 32; s++) retire_chk("R7 all marked", 0, 1, s, 1, 1);
  endtask

  task automatic t_restart();
    for (int s = 40; s <= 45; s++) alloc(0, s);
    squash(0, 44);
    squash(0, 41);
    chk("R9 restarted walk running", 32'(walk_done[0]), 0);
    idle(1);
    chk("R9 still walking", 32'(walk_done[0]), 0);
    chk("R9 tail pulse after restart", 32'(tail_update[0]), 1);
    idle(1);
    chk("R9 done with new boundary", 32'(walk_done[0]), 1);
    retire_chk("R9 seq40", 0, 1, 40, 0, 0);
    retire_chk("R9 seq41", 0, 1, 41, 0, 0);
    for (int s = 42; s <= 45; s++) retire_chk("R9 marked", 0, 1, s, 1, 1);
  endtask

  task automatic t_alloc_walking();
    for (int s = 50; s <= 52; s++) alloc(1, s);
    squash(1, 50);
    alloc(1, 99);
    chk("R6 done", 32'(walk_done[1]), 1);
    retire_chk("R10 seq50", 1, 1, 50, 0, 0);
    retire_chk("R10 seq51", 1, 1, 51, 1, 1);
    retire_chk("R10 seq52", 1, 1, 52, 1, 1);
    retire_chk("R10 alloc during walk dropped", 1, 0, 0, 0, 0);
  endtask

  task automatic t_full();
    for (int s = 60; s <= 68; s++) alloc(0, s);
    for (int s = 60; s <= 67; s++) retire_chk("R11 fifo order", 0, 1, s, 0, 0);
    retire_chk("R10 alloc when full dropped", 0, 0, 0, 0, 0);
  endtask

  task automatic t_independent();
    alloc(0, 70); alloc(0, 71); alloc(1, 80); alloc(1, 81);
    squash(1, 80);
    chk("R12 other thread done", 32'(walk_done[0]), 1);
    idle(1);
    chk("R12 walk done", 32'(walk_done), 32'h3);
    chk("R12 no pulse other thread", 32'(tail_update[0]), 0);
    retire_chk("R12 t0 seq70", 0, 1, 70, 0, 0);
    retire_chk("R12 t0 seq71", 0, 1, 71, 0, 0);
    retire_chk("R12 t1 seq80", 1, 1, 80, 0, 0);
    retire_chk("R12 t1 seq81", 1, 1, 81, 1, 1);
  endtask

  task automatic t_nothing_marked();
    alloc(0, 90); alloc(0, 91);
    squash(0, 91);
    chk("R3 done cleared", 32'(walk_done[0]), 0);
    idle(1);
    chk("R6 immediate stop", 32'(walk_done[0]), 1);
    chk("R8 no pulse when nothing marked", 32'(tail_update[0]), 0);
    retire_chk("R6 seq90", 0, 1, 90, 0, 0);
    retire_chk("R6 seq91", 0, 1, 91, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_empty_squash();
    t_basic();
    t_rate_retire();
    t_oldest();
    t_restart();
    t_alloc_walking();
    t_full();
    t_independent();
    t_nothing_marked();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule